// File: doc/BRIEF.md
# Memoized Split-Key Associative Lookup

This block is a small fully associative table, of the kind used for address translation, that returns a stored data word for a search key. Every entry holds a key and a data word. The key is split into an upper part and a lower part. Upper parts tend to repeat from one search to the next, so the block keeps one flag per entry that records whether that entry's upper part matched the last upper part that was broadcast. When a new search carries the same upper part as the previous search, and no entry has been written since, the upper comparators stay idle. Each entry then combines its stored flag with a fresh compare of the lower part only.

A search is presented with `lk_valid` and `lk_key`. The result is registered and appears on the next cycle: hit flag, lowest matching index, that entry's data, a flag for more than one match, and `hi_drive`. `hi_drive` marks the searches for which the upper part was broadcast and compared, which makes the saving visible to a power estimate. Entries are filled through a single write port. The boundary between the upper and lower parts is the parameter `LO_W`.

Top module: `splitkey_cam`

## Requirements
- R1: After reset all entries are invalid, `rsp_valid`, `rsp_hit` and `hi_drive` are 0, and the first search after reset broadcasts the upper part.
- R2: A search presented in cycle n gives `rsp_valid`=1 in cycle n+1 only. A cycle without `lk_valid` gives `rsp_valid`=0 in the following cycle.
- R3: A search whose full key equals the key of a valid entry gives `rsp_hit`=1, `rsp_idx` equal to that entry's index and `rsp_data` equal to that entry's data.
- R4: A search that matches no valid entry gives `rsp_hit`=0, `rsp_multi`=0, `rsp_idx`=0 and `rsp_data`=0.
- R5: `hi_drive` is 1 with a response exactly when the upper part differs from the previous search's upper part, or the search is the first since reset, or a write has happened since the previous search.
- R6: When the upper part repeats and nothing was written in between, `hi_drive` is 0 and the hit, index and data still equal those of a full compare.
- R7: A write with `wr_en` stores `wr_key` and `wr_data` into entry `wr_idx` and marks it valid. A search in the same cycle as a write sees the table as it was before the write.
- R8: When several valid entries match, `rsp_multi`=1 and the lowest matching index and its data are reported.
- R9: The lower part is `lk_key[LO_W-1:0]` and the upper part is `lk_key[KEY_W-1:LO_W]`. A difference in any single bit on either side of the boundary causes a miss.
- R10: Idle cycles between searches do not clear the stored upper match. A search after a gap that repeats the previous upper part gives `hi_drive`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Search request |
| lk_key | input | KEY_W | Search key |
| wr_en | input | 1 | Write an entry |
| wr_idx | input | IDX_W | Entry to write |
| wr_key | input | KEY_W | Key to store |
| wr_data | input | DATA_W | Data to store |
| rsp_valid | output | 1 | Result valid, one cycle after the search |
| rsp_hit | output | 1 | At least one entry matched |
| rsp_multi | output | 1 | More than one entry matched (error) |
| rsp_idx | output | IDX_W | Lowest matching index |
| rsp_data | output | DATA_W | Data of the reported entry |
| hi_drive | output | 1 | Upper part was broadcast and compared for this search |

## Verification
The hardest case to reach is a search that relies on stale per-entry upper-match flags. This happens after a write to an entry whose upper part equals the memoized one, and after a write that lands in the same cycle as a search. The stimulus sets up a run of searches that share an upper part and then inserts writes between them, including one that coincides with a search. Only a search that rebroadcasts the upper part gets these cases right. A scoreboard model tracks the last upper part and whether the memo is still valid, so the expected `hi_drive` is known for every response. A randomized phase over a small key alphabet then mixes repeats, changes and writes.

// File: rtl/splitkey_cam_pkg.sv
package splitkey_cam_pkg;
    // Defaults shared by the table and its bench.
    localparam int unsigned SK_KEY_W   = 40;
    localparam int unsigned SK_LO_W    = 12;
    localparam int unsigned SK_ENTRIES = 8;
    localparam int unsigned SK_DATA_W  = 16;

    // Flags carried with every registered response.
    typedef struct packed {
        logic valid;
        logic hit;
        logic multi;
        logic hdrive;
    } sk_rsp_flags_t;
endpackage

// File: rtl/splitkey_cam_entry.sv
module splitkey_cam_entry #(
    parameter int unsigned HI_W   = 28,
    parameter int unsigned LO_W   = 12,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [HI_W-1:0]   wr_hi,
    input  logic [LO_W-1:0]   wr_lo,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lk_valid,
    input  logic              bcast,
    input  logic [HI_W-1:0]   lk_hi,
    input  logic [LO_W-1:0]   lk_lo,
    output logic              match_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic              vld;
        logic              hm;
        logic [HI_W-1:0]   hi;
        logic [LO_W-1:0]   lo;
        logic [DATA_W-1:0] data;
    } ent_t;

    ent_t ent_d, ent_q;
    logic hi_eq, hm_use, lo_eq;

    always_comb begin
        // The upper comparator only sees the key on broadcast cycles.
        hi_eq  = bcast && (ent_q.hi == lk_hi);
        hm_use = bcast ? (ent_q.vld && hi_eq) : ent_q.hm;
        lo_eq  = (ent_q.lo == lk_lo);
        match_o = lk_valid && ent_q.vld && hm_use && lo_eq;
        data_o  = ent_q.data;

        ent_d = ent_q;
        if (bcast) begin
            ent_d.hm = ent_q.vld && hi_eq;
        end
        if (wr_sel) begin
            ent_d.vld  = 1'b1;
            ent_d.hm   = 1'b0;
            ent_d.hi   = wr_hi;
            ent_d.lo   = wr_lo;
            ent_d.data = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    // The stored upper flag only moves on a broadcast or a write.
    assert_hm_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bcast && !wr_sel) |=> $stable(ent_q.hm));

    // An empty slot never reports a match.
    assert_empty_nomatch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ent_q.vld) |-> !match_o);
endmodule

// File: rtl/splitkey_cam_pick.sv
module splitkey_cam_pick #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned DATA_W  = 16,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] match,
    input  logic [DATA_W-1:0]  data [ENTRIES],
    output logic               hit,
    output logic               multi,
    output logic [IDX_W-1:0]   idx,
    output logic [DATA_W-1:0]  sel_data
);
    always_comb begin
        hit   = 1'b0;
        multi = 1'b0;
        idx   = '0;
        for (int i = 0; i < int'(ENTRIES); i++) begin
            if (match[i]) begin
                if (hit) begin
                    multi = 1'b1;
                end else begin
                    hit = 1'b1;
                    idx = IDX_W'(i);
                end
            end
        end
        sel_data = hit ? data[idx] : '0;
    end
endmodule

// File: rtl/splitkey_cam.sv
module splitkey_cam
    import splitkey_cam_pkg::*;
#(
    parameter int unsigned KEY_W   = SK_KEY_W,
    parameter int unsigned LO_W    = SK_LO_W,
    parameter int unsigned ENTRIES = SK_ENTRIES,
    parameter int unsigned DATA_W  = SK_DATA_W,
    localparam int unsigned HI_W   = KEY_W - LO_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [KEY_W-1:0]  lk_key,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_multi,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [DATA_W-1:0] rsp_data,
    output logic              hi_drive
);
    typedef struct packed {
        logic              memo_ok;
        logic [HI_W-1:0]   last_hi;
        sk_rsp_flags_t     fl;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } top_t;

    top_t st_d, st_q;

    logic [HI_W-1:0]   lk_hi;
    logic [LO_W-1:0]   lk_lo;
    logic              bcast;
    logic [ENTRIES-1:0] ent_match;
    logic [DATA_W-1:0] ent_data [ENTRIES];
    logic              pk_hit, pk_multi;
    logic [IDX_W-1:0]  pk_idx;
    logic [DATA_W-1:0] pk_data;

    assign lk_hi = lk_key[KEY_W-1:LO_W];
    assign lk_lo = lk_key[LO_W-1:0];
    // Broadcast unless the memo is live and the upper part repeats.
    assign bcast = lk_valid && (!st_q.memo_ok || (lk_hi != st_q.last_hi));

    for (genvar g = 0; g < int'(ENTRIES); g++) begin : g_ent
        splitkey_cam_entry #(
            .HI_W(HI_W), .LO_W(LO_W), .DATA_W(DATA_W)
        ) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (wr_en && (wr_idx == IDX_W'(g))),
            .wr_hi    (wr_key[KEY_W-1:LO_W]),
            .wr_lo    (wr_key[LO_W-1:0]),
            .wr_data  (wr_data),
            .lk_valid (lk_valid),
            .bcast    (bcast),
            .lk_hi    (lk_hi),
            .lk_lo    (lk_lo),
            .match_o  (ent_match[g]),
            .data_o   (ent_data[g])
        );
    end

    splitkey_cam_pick #(
        .ENTRIES(ENTRIES), .DATA_W(DATA_W)
    ) u_pick (
        .match    (ent_match),
        .data     (ent_data),
        .hit      (pk_hit),
        .multi    (pk_multi),
        .idx      (pk_idx),
        .sel_data (pk_data)
    );

    always_comb begin
        st_d = st_q;
        st_d.fl.valid  = lk_valid;
        st_d.fl.hit    = lk_valid && pk_hit;
        st_d.fl.multi  = lk_valid && pk_multi;
        st_d.fl.hdrive = bcast;
        st_d.idx       = lk_valid ? pk_idx  : '0;
        st_d.data      = lk_valid ? pk_data : '0;
        if (lk_valid) begin
            st_d.memo_ok = 1'b1;
            st_d.last_hi = lk_hi;
        end
        if (wr_en) begin
            st_d.memo_ok = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.fl.valid;
    assign rsp_hit   = st_q.fl.hit;
    assign rsp_multi = st_q.fl.multi;
    assign hi_drive  = st_q.fl.hdrive;
    assign rsp_idx   = st_q.idx;
    assign rsp_data  = st_q.data;

    assert_resp_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    assert_no_resp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    assert_rearm_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (lk_valid |-> bcast));
    assert_repeat_skips_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !wr_en) ##1 (lk_valid && (lk_hi == $past(lk_hi))) |-> !bcast);
    assert_strobe_with_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hi_drive |-> rsp_valid);
    assert_multi_is_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multi |-> rsp_hit);
    assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_idx == '0 && rsp_data == '0));
endmodule

// File: tb/tb_splitkey_cam.sv
`timescale 1ns/1ps
module tb_splitkey_cam;
    localparam int KW = 40;
    localparam int LW = 12;
    localparam int HW = KW - LW;
    localparam int NE = 8;
    localparam int DW = 16;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [KW-1:0] lk_key = '0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [KW-1:0] wr_key = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rsp_valid, rsp_hit, rsp_multi, hi_drive;
    logic [IW-1:0] rsp_idx;
    logic [DW-1:0] rsp_data;

    splitkey_cam #(.KEY_W(KW), .LO_W(LW), .ENTRIES(NE), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_key(lk_key),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_key(wr_key), .wr_data(wr_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_multi(rsp_multi),
        .rsp_idx(rsp_idx), .rsp_data(rsp_data), .hi_drive(hi_drive)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic          hit;
        logic          multi;
        logic          hdrv;
        logic [IW-1:0] idx;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    // Reference model.
    logic          m_vld [NE];
    logic [KW-1:0] m_key [NE];
    logic [DW-1:0] m_dat [NE];
    logic          m_memo = 1'b0;
    logic [HW-1:0] m_last = '0;

    function automatic logic [KW-1:0] mk(input logic [HW-1:0] h, input logic [LW-1:0] l);
        return {h, l};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // One cycle of stimulus; a search pushes its expected response.
    task automatic step(input bit lv, input logic [KW-1:0] key, input bit we,
                        input int widx, input logic [KW-1:0] wkey,
                        input logic [DW-1:0] wdat, input string tag);
        exp_t e;
        if (lv) begin
            e.hit = 0; e.multi = 0; e.idx = '0; e.data = '0; e.tag = tag;
            e.hdrv = !m_memo || (key[KW-1:LW] != m_last);
            for (int i = 0; i < NE; i++) begin
                if (m_vld[i] && m_key[i] == key) begin
                    if (e.hit) e.multi = 1;
                    else begin e.hit = 1; e.idx = IW'(i); e.data = m_dat[i]; end
                end
            end
            exp_q.push_back(e);
            m_memo = 1'b1;
            m_last = key[KW-1:LW];
        end
        lk_valid = lv; lk_key = key;
        wr_en = we; wr_idx = IW'(widx); wr_key = wkey; wr_data = wdat;
        @(posedge clk); #1;
        if (we) begin
            m_vld[widx] = 1'b1; m_key[widx] = wkey; m_dat[widx] = wdat; m_memo = 1'b0;
        end
        lk_valid = 0; wr_en = 0;
    endtask

    task automatic look(input logic [KW-1:0] key, input string tag);
        step(1, key, 0, 0, '0, '0, tag);
    endtask
    task automatic wr(input int idx, input logic [KW-1:0] key, input logic [DW-1:0] d);
        step(0, '0, 1, idx, key, d, "R7");
    endtask

    // Monitor: compare each response against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R2", "unexpected rsp_valid", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rsp_hit == e.hit, e.tag, "hit", rsp_hit, e.hit);
                chk(rsp_multi == e.multi, e.tag, "multi", rsp_multi, e.multi);
                chk(rsp_idx == e.idx, e.tag, "idx", rsp_idx, e.idx);
                chk(rsp_data == e.data, e.tag, "data", rsp_data, e.data);
                chk(hi_drive == e.hdrv, e.tag, "hi_drive", hi_drive, e.hdrv);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    localparam logic [HW-1:0] HA = 28'h0ABC123;
    localparam logic [HW-1:0] HB = 28'h0ABC124;
    localparam logic [HW-1:0] HC = 28'h5555555;
    localparam logic [HW-1:0] HD = 28'hF000001;

    initial begin
        for (int i = 0; i < NE; i++) begin m_vld[i] = 0; m_key[i] = '0; m_dat[i] = '0; end
        repeat (3) @(posedge clk);
        #1;
        chk(rsp_valid == 0 && rsp_hit == 0 && hi_drive == 0, "R1", "reset outputs",
            {rsp_valid, rsp_hit, hi_drive}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        look(mk(HA, 12'h010), "R1");                  // empty table, first search
        wr(0, mk(HA, 12'h010), 16'h1111);
        wr(1, mk(HA, 12'h020), 16'h2222);
        wr(2, mk(HB, 12'h010), 16'h3333);
        wr(3, mk(HA, 12'h030), 16'h4444);
        look(mk(HA, 12'h020), "R3");                  // broadcast after writes
        look(mk(HA, 12'h030), "R6");                  // upper repeats
        step(0, '0, 0, 0, '0, '0, "R10");
        step(0, '0, 0, 0, '0, '0, "R10");
        #9;
        chk(rsp_valid == 0, "R2", "idle rsp_valid", rsp_valid, 0);
        @(posedge clk); #1;
        look(mk(HA, 12'h010), "R10");                 // memo survives gap
        look(mk(HB, 12'h010), "R5");
        look(mk(HB, 12'h020), "R4");
        look(mk(HA, 12'h999), "R4");
        step(1, mk(HA, 12'h040), 1, 4, mk(HA, 12'h040), 16'h5555, "R7");
        look(mk(HA, 12'h040), "R7");
        wr(6, mk(HA, 12'h010), 16'h6666);
        look(mk(HA, 12'h010), "R8");
        wr(5, mk(HC, 12'h777), 16'h7777);
        wr(7, mk(HC, 12'h777), 16'h8888);
        look(mk(HC, 12'h777), "R8");
        wr(0, mk(HD, 12'h010), 16'h9999);
        look(mk(HA, 12'h010), "R8");
        look(mk(HA ^ 28'h1, 12'h040), "R9");
        look(mk(HA, 12'h840), "R9");
        look(mk(HA, 12'h040), "R6");
        // Randomized mix over a small alphabet.
        for (int k = 0; k < 120; k++) begin
            logic [HW-1:0] h;
            logic [LW-1:0] l;
            int sel;
            sel = $urandom_range(0, 3);
            h = (sel == 0) ? HA : (sel == 1) ? HB : (sel == 2) ? HC : HD;
            l = LW'($urandom_range(0, 3) * 16 + 16);
            if ($urandom_range(0, 5) == 0)
                step($urandom_range(0, 1) == 1, mk(h, l), 1, $urandom_range(0, NE - 1),
                     mk(h, LW'($urandom_range(1, 4) * 16)), DW'($urandom), "R6");
            else if ($urandom_range(0, 6) == 0)
                step(0, '0, 0, 0, '0, '0, "R10");
            else
                look(mk(h, l), "R6");
        end
        repeat (3) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, "R2", "pending responses", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule